// File: doc/BRIEF.md
# Streaming Tag-Ordered Insertion Sorter

The block keeps a list of (tag, payload) entries in sorted order inside a row of identical cells. Every offered entry is presented to all cells in the same cycle. Each cell compares its own tag with the offered tag and then keeps its contents, takes the offered entry, or copies a neighbour. Only the tag is compared. The payload moves with its tag. The list depth, the tag width, the payload width and the ordering direction are fixed when the block is built.

The first cell is always the head of the list. Its valid bit, tag and payload are driven straight out of registers, so a consumer can look at the head tag before it decides to remove the entry. A removal request drops the head and moves every other entry one cell toward the head, which frees the last cell.

When every cell is occupied the block raises a full flag. It then keeps one more entry in a single-slot holding register. That entry enters the list as soon as a removal makes room. An insertion and a removal may be requested in the same cycle, and the block performs both.

Top module: `lsort_top`

## Requirements
- R1: After a synchronous reset the list is empty, so `head_valid`, `full` and `stall` are all 0.
- R2: With `ASCEND`=1 the entries run from the head in non-decreasing tag order, so the head holds the smallest tag present.
- R3: Entries with equal tags leave in the order they arrived. A new entry is placed after every stored entry with the same tag.
- R4: An entry offered with `in_valid`=1 while there is room is in the list on the next clock edge, so one entry can be accepted every cycle.
- R5: `full` is 1 exactly when all `DEPTH` cells hold valid entries.
- R6: An entry offered while the list is full and the holding slot is empty is kept in the slot. It enters the list on the first cycle in which a removal makes room, and it comes ahead of any entry offered in that same cycle.
- R7: `stall` is 1 when the list is full and the holding slot is occupied. An entry offered while `stall`=1 and `del_req`=0 is discarded and never appears at the head.
- R8: `del_req`=1 with a valid head removes the head. By the next edge the next entry in order is at the head, and the last cell is freed, so `full` drops when no entry is inserted in the same cycle.
- R9: `del_req`=1 while the list is empty has no effect. The list stays empty and the next insertion behaves normally.
- R10: When an insertion and a removal happen in the same cycle, the old head is removed and the new entry is placed at its correct position in the remaining list. The number of entries does not change.
- R11: With `ASCEND`=0 the ordering is reversed: the head holds the largest tag, and ties still keep arrival order.
- R12: The payload is not compared. The `head_data` shown with a head tag is always the payload that was offered together with that tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An entry is offered this cycle |
| in_tag | input | TAG_W | Sort key of the offered entry |
| in_data | input | DATA_W | Payload of the offered entry |
| del_req | input | 1 | Remove the head entry this cycle |
| head_valid | output | 1 | The head cell holds an entry |
| head_tag | output | TAG_W | Tag of the head entry |
| head_data | output | DATA_W | Payload of the head entry |
| full | output | 1 | Every cell is occupied |
| stall | output | 1 | List full and holding slot occupied; input without removal is lost |

## Verification
Insertion and head removal can fall in the same cycle. In that cycle each cell chooses between its right neighbour, the offered entry and its own contents in a frame that is already shifted. The bench raises `in_valid` and `del_req` together on purpose: against a partly filled list, against a full list with a held entry (where the slot drains and takes the new arrival), and with tags that land before, among and after the stored tags, including ties. Two instances, one ascending and one descending, get identical stimulus. After every edge the head, `full` and `stall` are compared with a bench model that applies the removal first and then the ordered insertion.

// File: rtl/lsort_pkg.sv
package lsort_pkg;

  typedef enum logic [1:0] {
    NODE_HOLD       = 2'd0,
    NODE_LOAD       = 2'd1,
    NODE_FROM_LEFT  = 2'd2,
    NODE_FROM_RIGHT = 2'd3
  } node_op_e;

  // g_* flags: the cell is empty or its tag orders strictly after the new tag.
  function automatic node_op_e pick_op(
    input logic ins,
    input logic pop,
    input logic is_head,
    input logic g_prev,
    input logic g_self,
    input logic g_next
  );
    node_op_e op;
    op = NODE_HOLD;
    if (pop && ins) begin
      // Work in the frame already shifted toward the head.
      if (!g_next)                 op = NODE_FROM_RIGHT;
      else if (is_head || !g_self) op = NODE_LOAD;
      else                         op = NODE_HOLD;
    end else if (pop) begin
      op = NODE_FROM_RIGHT;
    end else if (ins) begin
      if (g_prev)      op = NODE_FROM_LEFT;
      else if (g_self) op = NODE_LOAD;
      else             op = NODE_HOLD;
    end
    return op;
  endfunction

endpackage

// File: rtl/lsort_node.sv
module lsort_node
  import lsort_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int DATA_W = 16,
  parameter bit ASCEND = 1'b1,
  parameter bit HEAD   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins,
  input  logic              pop,
  input  logic              g_prev,
  input  logic              g_next,
  input  logic [TAG_W-1:0]  new_tag,
  input  logic [DATA_W-1:0] new_data,
  input  logic              left_v,
  input  logic [TAG_W-1:0]  left_tag,
  input  logic [DATA_W-1:0] left_data,
  input  logic              right_v,
  input  logic [TAG_W-1:0]  right_tag,
  input  logic [DATA_W-1:0] right_data,
  output logic              cur_v,
  output logic [TAG_W-1:0]  cur_tag,
  output logic [DATA_W-1:0] cur_data,
  output logic              g_out
);

  logic     after_new;
  node_op_e op;

  generate
    if (ASCEND) begin : g_asc
      assign after_new = cur_tag > new_tag;
    end else begin : g_desc
      assign after_new = cur_tag < new_tag;
    end
  endgenerate

  assign g_out = !cur_v || after_new;
  assign op    = pick_op(ins, pop, HEAD, g_prev, g_out, g_next);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_v    <= 1'b0;
      cur_tag  <= '0;
      cur_data <= '0;
    end else begin
      case (op)
        NODE_LOAD: begin
          cur_v    <= 1'b1;
          cur_tag  <= new_tag;
          cur_data <= new_data;
        end
        NODE_FROM_LEFT: begin
          cur_v    <= left_v;
          cur_tag  <= left_tag;
          cur_data <= left_data;
        end
        NODE_FROM_RIGHT: begin
          cur_v    <= right_v;
          cur_tag  <= right_tag;
          cur_data <= right_data;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lsort_ctrl.sv
module lsort_ctrl #(
  parameter int WORD_W = 32
) (
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              del_req,
  input  logic              head_v,
  input  logic              full,
  input  logic              buf_v,
  input  logic [WORD_W-1:0] buf_word,
  output logic              pop,
  output logic              ins,
  output logic              room,
  output logic [WORD_W-1:0] new_word
);

  assign pop      = del_req && head_v;
  assign room     = !full || pop;
  assign ins      = (buf_v || in_valid) && room;
  assign new_word = buf_v ? buf_word : in_word;

endmodule

// File: rtl/lsort_inbuf.sv
module lsort_inbuf #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              take,
  input  logic              room,
  output logic              buf_v,
  output logic [WORD_W-1:0] buf_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_v    <= 1'b0;
      buf_word <= '0;
    end else if (buf_v) begin
      if (take) begin
        buf_v    <= in_valid;
        buf_word <= in_word;
      end
    end else if (in_valid && !room) begin
      buf_v    <= 1'b1;
      buf_word <= in_word;
    end
  end

endmodule

// File: rtl/lsort_top.sv
module lsort_top #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 16,
  parameter int DATA_W = 16,
  parameter bit ASCEND = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  input  logic              del_req,
  output logic              head_valid,
  output logic [TAG_W-1:0]  head_tag,
  output logic [DATA_W-1:0] head_data,
  output logic              full,
  output logic              stall
);

  localparam int WORD_W = TAG_W + DATA_W;

  logic [DEPTH-1:0]             nv;
  logic [DEPTH-1:0]             ng;
  logic [DEPTH-1:0][TAG_W-1:0]  nt;
  logic [DEPTH-1:0][DATA_W-1:0] nd;

  logic              pop, ins, room, buf_v;
  logic [WORD_W-1:0] buf_word, new_word;
  logic [TAG_W-1:0]  new_tag;
  logic [DATA_W-1:0] new_data;

  assign full = nv[DEPTH-1];

  lsort_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .in_valid (in_valid),
    .in_word  ({in_tag, in_data}),
    .del_req  (del_req),
    .head_v   (nv[0]),
    .full     (full),
    .buf_v    (buf_v),
    .buf_word (buf_word),
    .pop      (pop),
    .ins      (ins),
    .room     (room),
    .new_word (new_word)
  );

  lsort_inbuf #(.WORD_W(WORD_W)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_word  ({in_tag, in_data}),
    .take     (ins),
    .room     (room),
    .buf_v    (buf_v),
    .buf_word (buf_word)
  );

  assign {new_tag, new_data} = new_word;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic              gp, gn, lv, rv;
      logic [TAG_W-1:0]  lt, rt;
      logic [DATA_W-1:0] ld, rd;

      if (i == 0) begin : g_first
        assign gp = 1'b0;
        assign lv = 1'b0;
        assign lt = '0;
        assign ld = '0;
      end else begin : g_mid_l
        assign gp = ng[i-1];
        assign lv = nv[i-1];
        assign lt = nt[i-1];
        assign ld = nd[i-1];
      end

      if (i == DEPTH-1) begin : g_last
        assign gn = 1'b1;
        assign rv = 1'b0;
        assign rt = '0;
        assign rd = '0;
      end else begin : g_mid_r
        assign gn = ng[i+1];
        assign rv = nv[i+1];
        assign rt = nt[i+1];
        assign rd = nd[i+1];
      end

      lsort_node #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .ASCEND (ASCEND),
        .HEAD   (i == 0)
      ) u_node (
        .clk        (clk),
        .rst        (rst),
        .ins        (ins),
        .pop        (pop),
        .g_prev     (gp),
        .g_next     (gn),
        .new_tag    (new_tag),
        .new_data   (new_data),
        .left_v     (lv),
        .left_tag   (lt),
        .left_data  (ld),
        .right_v    (rv),
        .right_tag  (rt),
        .right_data (rd),
        .cur_v      (nv[i]),
        .cur_tag    (nt[i]),
        .cur_data   (nd[i]),
        .g_out      (ng[i])
      );
    end
  endgenerate

  assign head_valid = nv[0];
  assign head_tag   = nt[0];
  assign head_data  = nd[0];
  assign stall      = full && buf_v;

endmodule

// File: rtl/lsort_chk.sv
module lsort_chk #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 16,
  parameter bit ASCEND = 1'b1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic                       del_req,
  input logic                       buf_v,
  input logic                       full,
  input logic [DEPTH-1:0]           nv,
  input logic [DEPTH-1:0][TAG_W-1:0] nt
);

  generate
    for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_pair
      // R5: occupied cells form a prefix, so the last cell marks full
      p_prefix_r5: assert property (@(posedge clk) disable iff (rst)
        nv[i+1] |-> nv[i]);
      if (ASCEND) begin : g_a
        p_order_r2: assert property (@(posedge clk) disable iff (rst)
          nv[i+1] |-> (nt[i] <= nt[i+1]));
      end else begin : g_d
        p_order_r11: assert property (@(posedge clk) disable iff (rst)
          nv[i+1] |-> (nt[i] >= nt[i+1]));
      end
    end
  endgenerate

  p_accept_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !full && !buf_v && !del_req)
      |=> ($countones(nv) == $past($countones(nv)) + 1));

  p_remove_r8: assert property (@(posedge clk) disable iff (rst)
    (del_req && nv[0] && !in_valid && !buf_v)
      |=> ($countones(nv) + 1 == $past($countones(nv))));

  p_both_r10: assert property (@(posedge clk) disable iff (rst)
    (del_req && nv[0] && in_valid && !buf_v)
      |=> ($countones(nv) == $past($countones(nv))));

  p_empty_del_r9: assert property (@(posedge clk) disable iff (rst)
    (!nv[0] && del_req && !in_valid && !buf_v) |=> !nv[0]);

  p_held_full_r6: assert property (@(posedge clk) disable iff (rst)
    buf_v |-> full);

endmodule

bind lsort_top lsort_chk #(
  .DEPTH  (DEPTH),
  .TAG_W  (TAG_W),
  .ASCEND (ASCEND)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .del_req  (del_req),
  .buf_v    (buf_v),
  .full     (full),
  .nv       (nv),
  .nt       (nt)
);

// File: tb/sim_lsort_top.sv
module sim_lsort_top;

  localparam int D  = 8;
  localparam int TW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic [DW-1:0] in_data = '0;
  logic del_req = 1'b0;

  logic hv0, hv1, f0, f1, s0, s1;
  logic [TW-1:0] ht0, ht1;
  logic [DW-1:0] hd0, hd1;

  always #2.5 clk = ~clk;

  lsort_top #(.DEPTH(D), .TAG_W(TW), .DATA_W(DW), .ASCEND(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
    .in_data(in_data), .del_req(del_req), .head_valid(hv0),
    .head_tag(ht0), .head_data(hd0), .full(f0), .stall(s0));

  lsort_top #(.DEPTH(D), .TAG_W(TW), .DATA_W(DW), .ASCEND(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
    .in_data(in_data), .del_req(del_req), .head_valid(hv1),
    .head_tag(ht1), .head_data(hd1), .full(f1), .stall(s1));

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  string phase = "R1 reset";
  int seq = 0;

  // model: index 0 ascending, index 1 descending
  int mt [2][D];
  int md [2][D];
  int mc [2];
  bit mbv [2];
  int mbt [2];
  int mbd [2];

  function automatic bit after_m(int k, int a, int b);
    return (k == 0) ? (a > b) : (a < b);
  endfunction

  task automatic model_step(int k, bit iv, int t, int d, bit dl);
    bit pop, room, have, ins;
    int ct, cd, pos;
    pop  = dl && (mc[k] > 0);
    room = (mc[k] < D) || pop;
    have = mbv[k] || iv;
    ct   = mbv[k] ? mbt[k] : t;
    cd   = mbv[k] ? mbd[k] : d;
    ins  = have && room;
    if (pop) begin
      for (int j = 0; j < D - 1; j++) begin
        mt[k][j] = mt[k][j+1];
        md[k][j] = md[k][j+1];
      end
      mc[k]--;
    end
    if (ins) begin
      pos = mc[k];
      for (int j = mc[k] - 1; j >= 0; j--)
        if (after_m(k, mt[k][j], ct)) pos = j;
      for (int j = mc[k]; j > pos; j--) begin
        mt[k][j] = mt[k][j-1];
        md[k][j] = md[k][j-1];
      end
      mt[k][pos] = ct;
      md[k][pos] = cd;
      mc[k]++;
    end
    if (mbv[k]) begin
      if (ins) begin
        mbv[k] = iv;
        mbt[k] = t;
        mbd[k] = d;
      end
    end else if (iv && !room) begin
      mbv[k] = 1'b1;
      mbt[k] = t;
      mbd[k] = d;
    end
  endtask

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("u0 head_valid R4", int'(hv0), int'(mc[0] > 0));
    chk("u1 head_valid R11", int'(hv1), int'(mc[1] > 0));
    if (mc[0] > 0) begin
      chk("u0 head_tag R2", int'(ht0), mt[0][0]);
      chk("u0 head_data R12", int'(hd0), md[0][0]);
    end
    if (mc[1] > 0) begin
      chk("u1 head_tag R11", int'(ht1), mt[1][0]);
      chk("u1 head_data R12", int'(hd1), md[1][0]);
    end
    chk("u0 full R5", int'(f0), int'(mc[0] == D));
    chk("u1 full R5", int'(f1), int'(mc[1] == D));
    chk("u0 stall R7", int'(s0), int'((mc[0] == D) && mbv[0]));
    chk("u1 stall R7", int'(s1), int'((mc[1] == D) && mbv[1]));
  endtask

  task automatic step(bit iv, int t, bit dl);
    int d;
    d = seq & 8'hFF;
    seq++;
    in_valid = iv;
    in_tag   = TW'(t);
    in_data  = DW'(d);
    del_req  = dl;
    @(posedge clk);
    for (int k = 0; k < 2; k++) model_step(k, iv, t & 8'hFF, d, dl);
    @(negedge clk);
    compare();
  endtask

  task automatic drain();
    for (int n = 0; n < D + 3; n++) step(1'b0, 0, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int tags3 [4];
    int r;
    for (int k = 0; k < 2; k++) begin
      mc[k] = 0; mbv[k] = 0; mbt[k] = 0; mbd[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    phase = "R1 reset";
    chk("R1 head_valid", int'(hv0), 0);
    chk("R1 full", int'(f0), 0);
    chk("R1 stall", int'(s0), 0);
    chk("R1 u1 head_valid", int'(hv1), 0);

    phase = "R4 R2 R12 insert burst";
    tags3 = '{9, 4, 12, 1};
    foreach (tags3[i]) step(1'b1, tags3[i], 1'b0);
    step(1'b1, 6, 1'b0);
    step(1'b1, 15, 1'b0);

    phase = "R8 drain";
    drain();
    phase = "R9 delete on empty";
    step(1'b0, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    chk("R9 head stays empty", int'(hv0), 0);
    step(1'b1, 5, 1'b0);
    chk("R9 insert after empty delete", int'(ht0), 5);

    phase = "R3 equal tags";
    for (int n = 0; n < 4; n++) step(1'b1, 5, 1'b0);
    step(1'b1, 3, 1'b0);
    drain();

    phase = "R5 R6 R7 overflow";
    for (int n = 0; n < D + 4; n++) step(1'b1, 20 - n, 1'b0);
    chk("R7 stall when full with held entry", int'(s0), 1);
    phase = "R10 R6 delete with held entry";
    step(1'b1, 0, 1'b1);
    step(1'b1, 30, 1'b1);
    step(1'b0, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    chk("R8 full drops after removal", int'(f0), 0);
    drain();

    phase = "R10 simultaneous insert and delete";
    for (int n = 0; n < 4; n++) step(1'b1, 10 + 2 * n, 1'b0);
    step(1'b1, 9, 1'b1);
    step(1'b1, 13, 1'b1);
    step(1'b1, 30, 1'b1);
    step(1'b1, 13, 1'b1);
    drain();

    phase = "random R2 R3 R10 R11";
    r = $urandom(32'h5EED);
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = $urandom_range(0, 99);
      step(sel < 60, $urandom_range(0, 15), (sel >= 40) && (sel < 85));
    end
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule